// File: doc/BRIEF.md
# Sequential Q15 Fractional Divider

This block divides one non-negative Q15 fraction by another and returns the quotient as a Q15 fraction. It is meant for fixed-point signal paths where a ratio with a magnitude no larger than one is needed (gain normalisation, energy ratios) and a handful of cycles of latency is cheaper than a combinational divider. The quotient is built by restoring division, one bit per clock, over exactly fifteen steps, with the partial remainder and the divisor kept in wide registers.

Operands enter on a valid/ready stream: a pair is taken on a clock edge where `in_valid` and `in_ready` are both high, and `in_ready` stays low for as long as a division is in flight, so a source simply keeps its next pair presented until it is taken. The result leaves on a second valid/ready stream: `out_valid` rises with the quotient and holds it, unchanged, until the sink raises `out_ready`; only after that hand-over does the unit accept new work. With `out_ready` held high, `out_valid` is a one-cycle pulse.

Two operand pairs skip the arithmetic result but not the schedule: equal operands give the largest positive fraction, and a zero divisor under a non-zero dividend gives that same saturated value with an error flag. Every division, shortcut or not, takes the same number of cycles.

Top module: `frac_div`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `in_ready` is 1 and `out_valid` is 0.
- R2: A pair is accepted only on an edge where `in_valid` and `in_ready` are both 1; `in_ready` is 1 exactly when no division is in flight and no result is waiting, so `in_valid` and operands presented while `in_ready` is 0 are ignored.
- R3: `out_valid` rises exactly 16 clock edges after the accepting edge (one preparation cycle plus 15 step cycles), for every operand pair including the shortcut cases of R5 and R6.
- R4: For 0 <= num < den (both with bit 15 clear), `out_q` equals floor(num * 32768 / den), so bit 15 of `out_q` is always 0.
- R5: When num equals den (including both zero), `out_q` is 16'h7FFF and `out_err` is 0.
- R6: When den is 0 and num is non-zero, `out_q` is 16'h7FFF and `out_err` is 1 while that result is presented; `out_err` is 0 whenever `out_valid` is 0 or the divisor was non-zero.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_q` and `out_err` keep their values; a result is handed over on an edge with both high, and `in_ready` is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair is presented |
| in_ready | output | 1 | Unit is idle and takes a pair this edge |
| in_num | input | 16 | Dividend, non-negative Q15 |
| in_den | input | 16 | Divisor, non-negative Q15, not below the dividend |
| out_valid | output | 1 | Quotient is presented |
| out_ready | input | 1 | Sink takes the quotient this edge |
| out_q | output | 16 | Quotient, Q15 |
| out_err | output | 1 | Presented result came from a zero divisor |

## Verification
The assertions take for granted that operands have bit 15 clear and that the dividend never exceeds the divisor except when the divisor is zero; outside that range the step sequence still runs for the same time but its quotient is not specified. The stimulus draws each divisor first and then a dividend no larger than it, adds a few zero-divisor and equal pairs on purpose, and toggles `out_ready` at random so that results are held under back-pressure while a new pair waits on the input stream.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_STEP = 2'd2,
    ST_HOLD = 2'd3
  } fdiv_state_e;

  // One restoring step on a remainder of width 32: shift, trial subtract.
  function automatic logic [32:0] restore_step(input logic [31:0] rem,
                                               input logic [31:0] dsr);
    logic [31:0] shifted;
    logic        take;
    shifted = {rem[30:0], 1'b0};
    take    = (shifted >= dsr);
    return {take, take ? (shifted - dsr) : shifted};
  endfunction

endpackage

// File: rtl/fdiv_ctrl.sv
module fdiv_ctrl
  import fdiv_pkg::*;
#(
  parameter int STEPS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic load_en,
  output logic step_en
);
  localparam int CNT_W = $clog2(STEPS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  fdiv_state_e      state, state_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_HOLD);
  assign load_en   = in_valid && in_ready;
  assign step_en   = (state == ST_STEP);

  always_comb begin
    state_nx = state;
    cnt_nx   = cnt;
    case (state)
      ST_IDLE: if (in_valid) state_nx = ST_PREP;
      ST_PREP: begin
        cnt_nx   = '0;
        state_nx = ST_STEP;
      end
      ST_STEP: begin
        if (cnt == LAST) state_nx = ST_HOLD;
        else             cnt_nx   = cnt + 1'b1;
      end
      ST_HOLD: if (out_ready) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_nx;
      cnt   <= cnt_nx;
    end
  end
endmodule

// File: rtl/fdiv_classify.sv
module fdiv_classify #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] num,
  input  logic [DATA_W-1:0] den,
  output logic              same_ops,
  output logic              zero_den
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      same_ops <= 1'b0;
      zero_den <= 1'b0;
    end else if (load_en) begin
      same_ops <= (num == den);
      zero_den <= (den == '0) && (num != '0);
    end
  end
endmodule

// File: rtl/fdiv_datapath.sv
module fdiv_datapath
  import fdiv_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              step_en,
  input  logic [DATA_W-1:0] num,
  input  logic [DATA_W-1:0] den,
  output logic [DATA_W-1:0] quo
);
  logic [ACC_W-1:0] rem, dsr;
  logic [32:0]      nxt;
  logic [31:0]      rem32, dsr32;

  generate
    if (ACC_W >= 32) begin : g_wide
      assign rem32 = rem[31:0];
      assign dsr32 = dsr[31:0];
    end else begin : g_narrow
      assign rem32 = {{(32-ACC_W){1'b0}}, rem};
      assign dsr32 = {{(32-ACC_W){1'b0}}, dsr};
    end
  endgenerate

  assign nxt = restore_step(rem32, dsr32);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0;
      dsr <= '0;
      quo <= '0;
    end else if (load_en) begin
      rem <= ACC_W'(num);
      dsr <= ACC_W'(den);
      quo <= '0;
    end else if (step_en) begin
      rem <= ACC_W'(nxt[31:0]);
      quo <= {quo[DATA_W-2:0], nxt[32]};
    end
  end
endmodule

// File: rtl/frac_div.sv
module frac_div #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_num,
  input  logic [DATA_W-1:0] in_den,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_q,
  output logic              out_err
);
  localparam int STEPS = DATA_W - 1;
  localparam logic [DATA_W-1:0] SAT_Q = {1'b0, {(DATA_W-1){1'b1}}};

  logic load_en, step_en, same_ops, zero_den;
  logic [DATA_W-1:0] quo;

  fdiv_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid),
    .load_en(load_en), .step_en(step_en)
  );

  fdiv_classify #(.DATA_W(DATA_W)) u_cls (
    .clk(clk), .rst_n(rst_n), .load_en(load_en),
    .num(in_num), .den(in_den),
    .same_ops(same_ops), .zero_den(zero_den)
  );

  fdiv_datapath #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .step_en(step_en),
    .num(in_num), .den(in_den), .quo(quo)
  );

  assign out_q   = (same_ops || zero_den) ? SAT_Q : quo;
  assign out_err = out_valid && zero_den;
endmodule

// File: rtl/frac_div_chk.sv
module frac_div_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_num,
  input logic [DATA_W-1:0] in_den,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_q,
  input logic              out_err
);
  localparam int LAT = DATA_W + 1;
  localparam int LW  = $clog2(LAT + 2);
  localparam logic [DATA_W-1:0] SAT_Q = {1'b0, {(DATA_W-1){1'b1}}};

  logic [LW-1:0]     lat;
  logic [DATA_W-1:0] cap_num, cap_den;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat <= '0; cap_num <= '0; cap_den <= '0;
    end else if (in_valid && in_ready) begin
      lat <= LW'(1); cap_num <= in_num; cap_den <= in_den;
    end else if (lat != '0 && !out_valid) begin
      lat <= lat + 1'b1;
    end else if (out_valid && out_ready) begin
      lat <= '0;
    end
  end

  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid); // R2
  AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (lat != '0 && !out_valid) |-> !in_ready); // R2
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat == LW'(LAT))); // R3
  AST_Q_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_q[DATA_W-1]); // R4
  AST_EQ_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_num == cap_den) |-> (out_q == SAT_Q && !out_err)); // R5
  AST_DZ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_den == '0 && cap_num != '0) |-> (out_q == SAT_Q && out_err)); // R6
  AST_ERR_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_valid && cap_den == '0)); // R6
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_q) && $stable(out_err))); // R7
  AST_READY_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> in_ready); // R7
endmodule

bind frac_div frac_div_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_num(in_num), .in_den(in_den), .out_valid(out_valid),
  .out_ready(out_ready), .out_q(out_q), .out_err(out_err)
);

// File: tb/sim_frac_div.sv
`timescale 1ns/1ps
module sim_frac_div;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, out_valid, out_ready, out_err;
  logic [15:0] in_num, in_den, out_q;

  always #4 clk = ~clk;

  frac_div u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_num(in_num), .in_den(in_den), .out_valid(out_valid),
    .out_ready(out_ready), .out_q(out_q), .out_err(out_err)
  );

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;
  logic [15:0] q_num[$], q_den[$];

  int          m_cnt = 0;
  bit          m_valid = 0;
  logic [15:0] m_q, p_q;
  bit          m_err, p_err;
  string       m_tag, p_tag;
  bit          prev_stall = 0;
  logic [15:0] prev_q;
  bit          prev_err;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic add_job(input logic [15:0] a, input logic [15:0] b);
    q_num.push_back(a);
    q_den.push_back(b);
  endtask

  function automatic bit m_idle();
    return (m_cnt == 0) && !m_valid;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done_flag) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_num = '0; in_den = '0;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

    add_job(16'h4000, 16'h7FFF);
    add_job(16'h1234, 16'h1234);   // R5
    add_job(16'h0000, 16'h0000);   // R5 both zero
    add_job(16'h0005, 16'h0000);   // R6
    add_job(16'h7FFF, 16'h0000);   // R6
    add_job(16'h0000, 16'h7FFF);   // R4 zero dividend
    add_job(16'h0001, 16'h7FFF);   // R4 smallest ratio
    add_job(16'h7FFE, 16'h7FFF);   // R4 largest below one
    add_job(16'h0001, 16'h0002);
    add_job(16'h3FFF, 16'h7FFF);
    add_job(16'h7FFF, 16'h7FFF);   // R5
    for (int i = 0; i < 180; i++) begin
      logic [15:0] d, n;
      d = 16'($urandom % 32768);
      n = (i % 23 == 7) ? 16'($urandom % 32768) : 16'($urandom % (int'(d) + 1));
      if (i % 23 == 7) d = 16'h0000;
      add_job(n, d);
    end

    while (q_num.size() != 0 || !m_idle()) begin
      @(negedge clk);
      // compare outputs against the model after the previous edge
      chk(in_ready == m_idle(), "R2", "in_ready", in_ready, m_idle());
      chk(out_valid == m_valid, "R3", "out_valid timing", out_valid, m_valid);
      if (m_valid && out_valid) begin
        chk(out_q == m_q, m_tag, "quotient", out_q, m_q);
        chk(out_err == m_err, "R6", "out_err with result", out_err, m_err);
      end else begin
        chk(out_err == 1'b0, "R6", "out_err without result", out_err, 0);
      end
      if (prev_stall) begin
        chk(out_valid && out_q == prev_q && out_err == prev_err, "R7",
            "held result", out_q, prev_q);
      end
      prev_stall = out_valid && !out_ready;
      prev_q     = out_q;
      prev_err   = out_err;

      // drive inputs for the next edge
      out_ready = ($urandom % 4) != 0;
      prev_stall = out_valid && !out_ready;
      if (q_num.size() != 0 && ($urandom % 6) != 0) begin
        in_valid = 1'b1;
        in_num   = q_num[0];
        in_den   = q_den[0];
      end else begin
        in_valid = (q_num.size() != 0) ? 1'b0 : ($urandom % 2 == 1);
        in_num   = 16'($urandom);
        in_den   = 16'($urandom);
        if (q_num.size() == 0) in_valid = 1'b0;
      end

      // advance the model across that edge
      if (in_valid && m_idle()) begin
        logic [15:0] a, b;
        a = q_num.pop_front();
        b = q_den.pop_front();
        if (a == b) begin
          p_q = 16'h7FFF; p_err = 0; p_tag = "R5";
        end else if (b == 0) begin
          p_q = 16'h7FFF; p_err = 1; p_tag = "R6";
        end else begin
          p_q = 16'((longint'(a) * 32768) / longint'(b)); p_err = 0; p_tag = "R4";
        end
        m_cnt = 16;
      end else if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_valid = 1; m_q = p_q; m_err = p_err; m_tag = p_tag;
        end
      end else if (m_valid && out_ready) begin
        m_valid = 0;
      end
    end
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R2", "idle at end", in_ready, 1);
    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule